// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Channel

This block is one transmit channel that drains a chain of buffer descriptors kept in ordinary memory. Each descriptor occupies four consecutive 32-bit words. Software gives the channel the address of the first descriptor. The channel then reads each descriptor and sends the bytes of its buffer on a byte-wide valid/ready stream. It writes the descriptor's mode word back with ownership handed to software, and then moves to the next descriptor in the chain.

A word-wide memory port carries every memory access, and only one access is in flight at a time. The engine holds its request until the port grants it. Read data comes back in the cycle after the grant.

A small register set controls the channel:
- a control register with an enable bit, a request to pause after the current packet, and a self-clearing soft reset;
- a head-pointer register that starts a chain;
- a completion-pointer register in which software acknowledges retired descriptors.

When the chain ends, the channel marks the last descriptor end-of-queue and waits. A new head write then restarts it.

Top module: `txq_dma_engine`

## Requirements
- R1: A descriptor at address A is read as four words in the order A (next pointer), A+4 (buffer pointer), A+8 (length, low 11 bits), A+12 (mode word). Mode bit 31 is start-of-packet, bit 30 is end-of-packet, bit 29 is owner and bit 28 is end-of-queue.
- R2: The buffer bytes are sent in address order, least significant byte of each word first. The number of bytes is the length field. tx_last is high on the final byte. tx_data stays stable while tx_valid is high and tx_ready is low.
- R3: After a descriptor's bytes have been sent, its mode word is written back to A+12. Bit 29 is cleared, bit 28 is set if the next pointer is zero, and all other bits are kept.
- R4: After writeback, a nonzero next pointer is followed at once. A zero next pointer leaves the channel idle.
- R5: A descriptor read with bit 29 clear sends no bytes, gets no writeback, and leaves the channel idle.
- R6: Register select codes are 0 for control, 1 for head and 2 for completion. A nonzero head write to an idle channel with nothing pending loads head_ptr and arms a start. A head write of zero changes nothing.
- R7: A nonzero head write while the channel is running, or while a start is already pending, leaves head_ptr unchanged and sets head_err. head_err stays set until soft reset.
- R8: Once the channel has stopped at end-of-queue, a new head write restarts processing at the written descriptor.
- R9: Control bit 0 is the enable. An armed start does not begin while the enable is clear.
- R10: Control bit 1 requests idle. The current packet finishes and is written back, and the channel then stops. The next pointer is kept as a pending head, and stat_idle is high. Clearing the request resumes at that next descriptor.
- R11: Writing control bit 2 raises srst_busy for exactly one cycle. This clears head_ptr, the pending start, head_err and cmpl_ptr, and stops the channel.
- R12: A completion write loads cmpl_ptr with the written value.
- R13: mem_req, mem_we and mem_addr stay constant until mem_gnt.
- R14: A descriptor with length zero sends no bytes and issues no buffer read, but is still written back as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 head, 2 completion |
| reg_wdata | input | 32 | Register write data |
| head_ptr | output | ADDR_W | Current head-pointer register |
| cmpl_ptr | output | ADDR_W | Completion-pointer register |
| head_err | output | 1 | Sticky flag for a rejected head write |
| srst_busy | output | 1 | Soft reset in progress |
| stat_idle | output | 1 | Channel stopped with no start about to begin |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Grant for the current request |
| mem_rdata | input | 32 | Read data, valid the cycle after the grant |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream byte accepted |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the buffer |

## Verification
The bench runs a three-descriptor chain whose middle entry has length zero. A design that read a buffer for it, or skipped its writeback, would show up in the recorded access trace. A head write made mid-chain must bounce off and set the error flag without moving the pointer. Restarting after end-of-queue, and a descriptor still owned by software, catch a design that keeps running or writes back anyway. A pause request raised while the stream is stalled must let that packet finish and hold the next descriptor untouched until the request drops. A soft reset must wipe the pending start, so a later enable starts nothing.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int DW        = 32;
  localparam int MODE_SOP  = 31;
  localparam int MODE_EOP  = 30;
  localparam int MODE_OWN  = 29;
  localparam int MODE_EOQ  = 28;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_HEAD = 2'd1;
  localparam logic [1:0] SEL_CMPL = 2'd2;

  typedef enum logic [2:0] {
    W_IDLE, W_RD_REQ, W_RD_DAT, W_CHECK, W_BUF_REQ, W_BUF_DAT, W_SEND, W_WB_REQ
  } walk_st_e;

  // mode word returned to software: ownership dropped, end-of-queue on chain end
  function automatic logic [DW-1:0] retire_word(input logic [DW-1:0] mode,
                                                input logic chain_end);
    logic [DW-1:0] r;
    r = mode;
    r[MODE_OWN] = 1'b0;
    r[MODE_EOQ] = mode[MODE_EOQ] | chain_end;
    return r;
  endfunction

  function automatic logic [7:0] byte_lane(input logic [DW-1:0] w, input logic [1:0] sel);
    return w[{3'd0, sel} * 8 +: 8];
  endfunction
endpackage

// File: rtl/txq_ctrl_regs.sv
module txq_ctrl_regs
  import txq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              wlk_busy,
  input  logic              take,
  input  logic              park,
  input  logic [ADDR_W-1:0] park_ptr,
  output logic              chan_en,
  output logic              idle_req,
  output logic [ADDR_W-1:0] head_ptr,
  output logic              head_pend,
  output logic              head_err,
  output logic [ADDR_W-1:0] cmpl_ptr,
  output logic              soft_clr
);
  logic head_wr, head_nz, head_ok, head_bad;

  assign head_wr  = reg_we && (reg_sel == SEL_HEAD);
  assign head_nz  = reg_wdata[ADDR_W-1:0] != '0;
  assign head_ok  = head_wr && head_nz && !wlk_busy && !head_pend;
  assign head_bad = head_wr && head_nz && (wlk_busy || head_pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en <= 1'b0; idle_req <= 1'b0; soft_clr <= 1'b0;
      head_ptr <= '0; head_pend <= 1'b0; head_err <= 1'b0; cmpl_ptr <= '0;
    end else if (soft_clr) begin
      soft_clr <= 1'b0;
      head_ptr <= '0; head_pend <= 1'b0; head_err <= 1'b0; cmpl_ptr <= '0;
    end else begin
      if (reg_we && reg_sel == SEL_CTRL) begin
        chan_en  <= reg_wdata[0];
        idle_req <= reg_wdata[1];
        soft_clr <= reg_wdata[2];
      end
      if (reg_we && reg_sel == SEL_CMPL) cmpl_ptr <= reg_wdata[ADDR_W-1:0];
      if (head_ok) begin
        head_ptr  <= reg_wdata[ADDR_W-1:0];
        head_pend <= 1'b1;
      end
      if (head_bad) head_err <= 1'b1;
      if (take) head_pend <= 1'b0;
      if (park) begin
        head_ptr  <= park_ptr;
        head_pend <= 1'b1;
      end
    end
  end

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
    head_err |=> head_err);
  p_take_needs_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> head_pend);
  p_srst_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> !soft_clr);
endmodule

// File: rtl/txq_walker.sv
module txq_walker
  import txq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              go,
  input  logic              idle_req,
  input  logic [ADDR_W-1:0] head_ptr,
  output logic              busy,
  output logic              take,
  output logic              park,
  output logic [ADDR_W-1:0] park_ptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_gnt,
  input  logic [DW-1:0]     mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last
);
  localparam int WB_OFS = 12;

  walk_st_e          st_q;
  logic [1:0]        idx_q, sel_q;
  logic [ADDR_W-1:0] cur_q, nxt_q, buf_q;
  logic [LEN_W-1:0]  left_q;
  logic [DW-1:0]     mode_q, word_q;
  logic              chain_end;

  assign chain_end = (nxt_q == '0);
  assign busy      = (st_q != W_IDLE);
  assign take      = (st_q == W_IDLE) && go && !soft_clr;
  assign park      = (st_q == W_WB_REQ) && mem_gnt && !chain_end && idle_req && !soft_clr;
  assign park_ptr  = nxt_q;

  assign mem_req   = (st_q == W_RD_REQ) || (st_q == W_BUF_REQ) || (st_q == W_WB_REQ);
  assign mem_we    = (st_q == W_WB_REQ);
  assign mem_wdata = retire_word(mode_q, chain_end);
  always_comb begin
    case (st_q)
      W_RD_REQ:  mem_addr = cur_q + {{(ADDR_W-4){1'b0}}, idx_q, 2'b00};
      W_BUF_REQ: mem_addr = buf_q;
      default:   mem_addr = cur_q + ADDR_W'(WB_OFS);
    endcase
  end

  assign tx_valid = (st_q == W_SEND);
  assign tx_data  = byte_lane(word_q, sel_q);
  assign tx_last  = tx_valid && (left_q == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= W_IDLE; idx_q <= '0; sel_q <= '0; cur_q <= '0; nxt_q <= '0;
      buf_q <= '0; left_q <= '0; mode_q <= '0; word_q <= '0;
    end else if (soft_clr) begin
      st_q <= W_IDLE;
    end else begin
      case (st_q)
        W_IDLE: if (go) begin
          cur_q <= head_ptr; idx_q <= '0; st_q <= W_RD_REQ;
        end
        W_RD_REQ: if (mem_gnt) st_q <= W_RD_DAT;
        W_RD_DAT: begin
          case (idx_q)
            2'd0:    nxt_q  <= mem_rdata[ADDR_W-1:0];
            2'd1:    buf_q  <= mem_rdata[ADDR_W-1:0];
            2'd2:    left_q <= mem_rdata[LEN_W-1:0];
            default: mode_q <= mem_rdata;
          endcase
          if (idx_q == 2'd3) st_q <= W_CHECK;
          else begin
            idx_q <= idx_q + 2'd1; st_q <= W_RD_REQ;
          end
        end
        W_CHECK: begin
          if (!mode_q[MODE_OWN])   st_q <= W_IDLE;
          else if (left_q == '0)   st_q <= W_WB_REQ;
          else begin
            sel_q <= '0; st_q <= W_BUF_REQ;
          end
        end
        W_BUF_REQ: if (mem_gnt) st_q <= W_BUF_DAT;
        W_BUF_DAT: begin
          word_q <= mem_rdata;
          buf_q  <= buf_q + ADDR_W'(4);
          st_q   <= W_SEND;
        end
        W_SEND: if (tx_ready) begin
          left_q <= left_q - LEN_W'(1);
          sel_q  <= sel_q + 2'd1;
          if (left_q == LEN_W'(1)) st_q <= W_WB_REQ;
          else if (sel_q == 2'd3)  st_q <= W_BUF_REQ;
        end
        W_WB_REQ: if (mem_gnt) begin
          if (chain_end || idle_req) st_q <= W_IDLE;
          else begin
            cur_q <= nxt_q; idx_q <= '0; st_q <= W_RD_REQ;
          end
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  p_wb_owner_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[MODE_OWN]);
  p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  p_park_on_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
    park |-> idle_req);
endmodule

// File: rtl/txq_dma_engine.sv
module txq_dma_engine
  import txq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [ADDR_W-1:0] head_ptr,
  output logic [ADDR_W-1:0] cmpl_ptr,
  output logic              head_err,
  output logic              srst_busy,
  output logic              stat_idle,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last
);
  logic chan_en, idle_req, head_pend, soft_clr;
  logic busy, take, park, go;
  logic [ADDR_W-1:0] park_ptr;

  assign go        = head_pend && chan_en && !idle_req;
  assign stat_idle = !busy && !go;
  assign srst_busy = soft_clr;

  txq_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .reg_we, .reg_sel, .reg_wdata,
    .wlk_busy(busy), .take, .park, .park_ptr,
    .chan_en, .idle_req, .head_ptr, .head_pend, .head_err, .cmpl_ptr, .soft_clr
  );

  txq_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walk (
    .clk, .rst_n, .soft_clr, .go, .idle_req, .head_ptr,
    .busy, .take, .park, .park_ptr,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_gnt, .mem_rdata,
    .tx_valid, .tx_ready, .tx_data, .tx_last
  );
endmodule

// File: tb/test_txq_dma_engine.sv
module test_txq_dma_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd3;
  logic [31:0] reg_wdata = '0;
  logic [31:0] head_ptr, cmpl_ptr, mem_addr, mem_wdata, mem_rdata;
  logic        head_err, srst_busy, stat_idle, mem_req, mem_we, mem_gnt;
  logic        tx_valid, tx_ready, tx_last;
  logic [7:0]  tx_data;

  txq_dma_engine i_txq_dma_engine (
    .clk, .rst_n, .reg_we, .reg_sel, .reg_wdata, .head_ptr, .cmpl_ptr, .head_err,
    .srst_busy, .stat_idle, .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_gnt,
    .mem_rdata, .tx_valid, .tx_ready, .tx_data, .tx_last
  );

  int n_cmp = 0, n_bad = 0;
  logic done = 1'b0;

  // memory model: 1 KB, host poke port for setup
  logic [31:0] mem [0:255];
  logic        host_we = 1'b0;
  logic [7:0]  host_idx = '0;
  logic [31:0] host_data = '0;
  logic        gnt_allow = 1'b1, hold = 1'b0, rdy_pat = 1'b1;
  int          cyc = 0;

  assign mem_gnt  = mem_req && gnt_allow;
  assign tx_ready = rdy_pat && !hold;

  always @(posedge clk) begin
    if (host_we) mem[host_idx] <= host_data;
    else if (mem_req && mem_gnt && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (mem_req && mem_gnt && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
  end

  always @(posedge clk) begin
    #1;
    cyc++;
    gnt_allow = (cyc % 3) != 1;
    rdy_pat   = (cyc % 4) != 2;
  end

  function automatic logic [7:0] byte_at(input int a);
    return 8'((a * 5 + 1) & 255);
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [8:0]  exp_q[$];
  logic [32:0] trace_q[$];

  task automatic expect_bytes(input int bufa, input int len);
    for (int k = 0; k < len; k++) exp_q.push_back({k == len - 1, byte_at(bufa + k)});
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_req && mem_gnt) trace_q.push_back({mem_we, mem_addr});
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R2/R5 unexpected byte", {23'd0, tx_last, tx_data}, 32'h0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check({tx_last, tx_data} == e, "R2 stream byte", {23'd0, tx_last, tx_data}, {23'd0, e});
      end
    end
  end

  task automatic poke(input int addr, input logic [31:0] d);
    @(posedge clk); #1;
    host_we = 1'b1; host_idx = 8'(addr >> 2); host_data = d;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  function automatic logic [31:0] mode_of(input int len, input logic own);
    return 32'hC000_0000 | ({31'd0, own} << 29) | 32'(len);
  endfunction

  task automatic put_desc(input int a, input int nxt, input int bufa, input int len, input logic own);
    poke(a, 32'(nxt)); poke(a + 4, 32'(bufa)); poke(a + 8, 32'(len)); poke(a + 12, mode_of(len, own));
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_sel = 2'd3;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    @(negedge clk);
    while (!stat_idle && n < 3000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 32'(cyc), 32'h0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++)
      mem[i] = {byte_at(4*i+3), byte_at(4*i+2), byte_at(4*i+1), byte_at(4*i)};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(stat_idle && !head_err && !srst_busy && !tx_valid && !mem_req, "reset idle", {27'd0, stat_idle, head_err, srst_busy, tx_valid, mem_req}, 32'h10);
    check(head_ptr == 0 && cmpl_ptr == 0, "reset regs", head_ptr | cmpl_ptr, 32'h0);

    // chain: D0 -> D1 (zero length) -> D2
    put_desc('h40, 'h60, 'h100, 5, 1'b1);
    put_desc('h60, 'h80, 'h120, 0, 1'b1);
    put_desc('h80, 0, 'h140, 9, 1'b1);
    expect_bytes('h100, 5); expect_bytes('h140, 9);
    trace_q.delete();
    wr_reg(2'd1, 32'h40);
    repeat (10) @(negedge clk);
    check(head_ptr == 32'h40, "R6 head loaded", head_ptr, 32'h40);
    check(stat_idle && trace_q.size() == 0, "R9 no start while disabled", 32'(trace_q.size()), 32'h0);
    wr_reg(2'd0, 32'h1);
    wr_reg(2'd1, 32'h200);
    @(negedge clk);
    check(head_err == 1'b1, "R7 busy head write flagged", {31'd0, head_err}, 32'h1);
    check(head_ptr == 32'h40, "R7 head unchanged", head_ptr, 32'h40);
    wait_idle();
    check(trace_q.size() >= 12, "R1 trace length", 32'(trace_q.size()), 32'd12);
    if (trace_q.size() >= 12) begin
      check(trace_q[0] == {1'b0, 32'h40} && trace_q[1] == {1'b0, 32'h44}, "R1 word order a", trace_q[1][31:0], 32'h44);
      check(trace_q[2] == {1'b0, 32'h48} && trace_q[3] == {1'b0, 32'h4C}, "R1 word order b", trace_q[3][31:0], 32'h4C);
      check(trace_q[4] == {1'b0, 32'h100} && trace_q[5] == {1'b0, 32'h104}, "R2 buffer reads", trace_q[5][31:0], 32'h104);
      check(trace_q[6] == {1'b1, 32'h4C}, "R3 writeback D0", trace_q[6][31:0], 32'h4C);
      check(trace_q[7] == {1'b0, 32'h60} && trace_q[10] == {1'b0, 32'h6C}, "R4 follows next", trace_q[7][31:0], 32'h60);
      check(trace_q[11] == {1'b1, 32'h6C}, "R14 zero length no buffer read", trace_q[11][31:0], 32'h6C);
    end
    check(mem['h4C >> 2] == 32'hC000_0005, "R3 D0 owner cleared", mem['h4C >> 2], 32'hC000_0005);
    check(mem['h6C >> 2] == 32'hC000_0000, "R14 D1 written back", mem['h6C >> 2], 32'hC000_0000);
    check(mem['h8C >> 2] == 32'hD000_0009, "R3 D2 end of queue", mem['h8C >> 2], 32'hD000_0009);
    check(exp_q.size() == 0, "R2 all bytes sent", 32'(exp_q.size()), 32'h0);

    // zero head write ignored, then restart after end-of-queue
    wr_reg(2'd1, 32'h0);
    repeat (4) @(negedge clk);
    check(head_ptr == 32'h40 && stat_idle, "R6 zero head ignored", head_ptr, 32'h40);
    put_desc('hA0, 0, 'h160, 6, 1'b1);
    expect_bytes('h160, 6);
    wr_reg(2'd1, 32'hA0);
    wait_idle();
    check(mem['hAC >> 2] == 32'hD000_0006, "R8 restart written back", mem['hAC >> 2], 32'hD000_0006);
    check(exp_q.size() == 0, "R8 restart bytes", 32'(exp_q.size()), 32'h0);

    // descriptor not owned
    put_desc('hC0, 0, 'h170, 4, 1'b0);
    trace_q.delete();
    wr_reg(2'd1, 32'hC0);
    wait_idle();
    repeat (4) @(negedge clk);
    check(trace_q.size() == 4 && trace_q[3] == {1'b0, 32'hCC}, "R5 fetch only", 32'(trace_q.size()), 32'h4);
    check(mem['hCC >> 2] == mode_of(4, 1'b0), "R5 no writeback", mem['hCC >> 2], mode_of(4, 1'b0));

    // idle request during a packet
    put_desc('hE0, 'h20, 'h180, 7, 1'b1);
    put_desc('h20, 0, 'h1A0, 3, 1'b1);
    expect_bytes('h180, 7); expect_bytes('h1A0, 3);
    hold = 1'b1;
    wr_reg(2'd1, 32'hE0);
    begin
      int n;
      n = 0;
      @(negedge clk);
      while (!tx_valid && n < 200) begin @(negedge clk); n++; end
    end
    wr_reg(2'd0, 32'h3);
    hold = 1'b0;
    wait_idle();
    check(mem['hEC >> 2] == 32'hC000_0007, "R10 current packet finished", mem['hEC >> 2], 32'hC000_0007);
    check(mem['h2C >> 2] == mode_of(3, 1'b1), "R10 next untouched", mem['h2C >> 2], mode_of(3, 1'b1));
    check(head_ptr == 32'h20 && stat_idle, "R10 parked at next", head_ptr, 32'h20);
    check(exp_q.size() == 3, "R10 remaining bytes", 32'(exp_q.size()), 32'h3);
    wr_reg(2'd0, 32'h1);
    wait_idle();
    check(mem['h2C >> 2] == 32'hD000_0003, "R10 resumed", mem['h2C >> 2], 32'hD000_0003);
    check(exp_q.size() == 0, "R10 resumed bytes", 32'(exp_q.size()), 32'h0);

    // completion register and soft reset
    wr_reg(2'd2, 32'h2C);
    @(negedge clk);
    check(cmpl_ptr == 32'h2C, "R12 completion readback", cmpl_ptr, 32'h2C);
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd1, 32'h40);
    wr_reg(2'd1, 32'h60);
    @(negedge clk);
    check(head_ptr == 32'h40 && head_err, "R7 pending head write rejected", head_ptr, 32'h40);
    wr_reg(2'd0, 32'h4);
    @(negedge clk);
    check(srst_busy == 1'b1, "R11 reset raised", {31'd0, srst_busy}, 32'h1);
    @(negedge clk);
    check(!srst_busy && head_ptr == 0 && !head_err && cmpl_ptr == 0, "R11 state cleared",
          head_ptr | cmpl_ptr | {30'd0, srst_busy, head_err}, 32'h0);
    trace_q.delete();
    wr_reg(2'd0, 32'h1);
    repeat (20) @(negedge clk);
    check(stat_idle && trace_q.size() == 0, "R11 pending start dropped", 32'(trace_q.size()), 32'h0);
    finish_run();
  end
endmodule